// File: doc/BRIEF.md
# Socket Status Change Latch

This block is the per-socket status-change capture register of a removable-card host adapter. It watches five card-side lines: two active-low card-detect lines, a ready / interrupt-request line, and two battery-voltage-detect lines. Each line first passes through its own synchroniser. Qualified edges on these lines set sticky flags, which the host reads through a small register read port. The act of reading clears all of the flags.

A mode input selects memory-card or I/O-card behaviour, and the mode changes how edges are qualified. In memory-card mode the first battery line counts only falling edges. In I/O-card mode it counts both edges. The second battery flag and the ready flag are suppressed in I/O-card mode. A four-bit enable mask, supplied by a separate configuration register, gates each flag. The OR of the visible flags drives a management-interrupt output.

Top module: `sock_chg_latch`

## Requirements
- R1: After reset, rdData is 0, rdValid is 0 and mgmtIrq is 0.
- R2: Bit 3 of the status value is set by a rise or a fall on either cardDet1N or cardDet2N, in both modes.
- R3: In memory-card mode (ioMode=0), bit 0 is set by a falling edge on bvd1. A rising edge on bvd1 leaves it clear.
- R4: In I/O-card mode (ioMode=1), bit 0 is set by either a rising or a falling edge on bvd1.
- R5: Bit 1 is set by a falling edge on bvd2 in memory-card mode. A rising edge, or any edge in I/O-card mode, leaves it clear.
- R6: Bit 2 is set by any edge on rdyIreq in memory-card mode. Bit 2 reads 0 and does not raise mgmtIrq while ioMode=1.
- R7: A status bit is set only when the enMask bit at the same position is 1.
- R8: A read happens when rdStrobe is high and rdIndex equals REG_INDEX. rdValid then pulses for one cycle after the strobe cycle. In that cycle rdData holds {4'b0, status}. A strobe with any other index has no effect.
- R9: A read clears all status bits. If an edge event lands in the same cycle as the read, the read returns the value from before the clear, and the event's bit stays set.
- R10: mgmtIrq is high exactly when some visible status bit is set. It drops in the cycle after a read that coincides with no new event.
- R11: An input change becomes visible on mgmtIrq three clock edges after it is sampled, because of the two synchroniser stages and the edge-detect stage. Edges are ignored until the synchroniser has filled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioMode | input | 1 | 1 selects I/O-card behaviour, 0 selects memory-card behaviour |
| enMask | input | 4 | Per-bit detection enables, in the same bit order as the status value |
| cardDet1N | input | 1 | First active-low card-detect line (asynchronous) |
| cardDet2N | input | 1 | Second active-low card-detect line (asynchronous) |
| rdyIreq | input | 1 | Ready / interrupt-request line (asynchronous) |
| bvd1 | input | 1 | First battery-voltage-detect / status-change line (asynchronous) |
| bvd2 | input | 1 | Second battery-voltage-detect line (asynchronous) |
| rdStrobe | input | 1 | Single-cycle read strobe |
| rdIndex | input | IDX_W | Register index accompanying rdStrobe |
| rdData | output | DATA_W | Registered read data |
| rdValid | output | 1 | Pulses one cycle after an accepted read |
| mgmtIrq | output | 1 | Management interrupt, OR of the visible status bits |

## Verification
A status bit stuck at 1 shows as mgmtIrq still high in the cycle after a clean read, and as a non-zero value on the next read. A missed edge shows as mgmtIrq still low three edges after the input change. A wrong mode qualifier shows as a flag appearing, or not appearing, on the very next read after a single edge. A lost collision event is caught by a second read, which returns 0 where it should return the set bit.

// File: rtl/sock_chg_pkg.sv
package sock_chg_pkg;
  localparam int NUM_BITS = 4;
  localparam int NUM_PINS = 5;

  // pin positions inside the synchronised vector
  localparam int PIN_CD1  = 0;
  localparam int PIN_CD2  = 1;
  localparam int PIN_RDY  = 2;
  localparam int PIN_BVD1 = 3;
  localparam int PIN_BVD2 = 4;

  // status bit positions (host software decodes these)
  localparam int ST_BATDEAD = 0;
  localparam int ST_BATWARN = 1;
  localparam int ST_READY   = 2;
  localparam int ST_CARDDET = 3;

  typedef struct packed {
    logic rdHit;   // accepted read this cycle: capture and clear
  } ctrlStrb_t;
endpackage

// File: rtl/sock_chg_sync.sv
module sock_chg_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sock_chg_ctrl.sv
module sock_chg_ctrl
  import sock_chg_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] REG_INDEX = 8'h04
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStrobe,
  input  logic [IDX_W-1:0] rdIndex,
  output ctrlStrb_t        strb,
  output logic             rdValid
);
  logic idxMatch;

  assign idxMatch   = (rdIndex == REG_INDEX);
  assign strb.rdHit = rdStrobe && idxMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strb.rdHit;
  end
endmodule

// File: rtl/sock_chg_dp.sv
module sock_chg_dp
  import sock_chg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioMode,
  input  logic [NUM_BITS-1:0] enMask,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  ctrlStrb_t           strb,
  output logic [DATA_W-1:0]   rdData,
  output logic                mgmtIrq,
  output logic [NUM_BITS-1:0] statusQ,
  output logic [NUM_BITS-1:0] setVec
);
  localparam int WARM_W = SYNC_STAGES + 1;
  localparam int PAD_W  = DATA_W - NUM_BITS;

  logic [NUM_PINS-1:0] pinSync, pinPrev, riseEv, fallEv, anyEv;
  logic [WARM_W-1:0]   warm;
  logic                armed;
  logic [NUM_BITS-1:0] rawSet, visible;

  sock_chg_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinRaw),
    .dout(pinSync)
  );

  // history flop plus warm-up shifter: edges count only once the chain is full
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= '0;
      warm    <= '0;
    end else begin
      pinPrev <= pinSync;
      warm    <= {warm[WARM_W-2:0], 1'b1};
    end
  end

  assign armed  = warm[WARM_W-1];
  assign riseEv = {NUM_PINS{armed}} & pinSync & ~pinPrev;
  assign fallEv = {NUM_PINS{armed}} & ~pinSync & pinPrev;
  assign anyEv  = riseEv | fallEv;

  always_comb begin
    rawSet              = '0;
    rawSet[ST_BATDEAD]  = ioMode ? anyEv[PIN_BVD1] : fallEv[PIN_BVD1];
    rawSet[ST_BATWARN]  = !ioMode && fallEv[PIN_BVD2];
    rawSet[ST_READY]    = !ioMode && anyEv[PIN_RDY];
    rawSet[ST_CARDDET]  = anyEv[PIN_CD1] || anyEv[PIN_CD2];
  end

  assign setVec = rawSet & enMask;

  // new events win over the read clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~{NUM_BITS{strb.rdHit}}) | setVec;
  end

  always_comb begin
    visible           = statusQ;
    visible[ST_READY] = statusQ[ST_READY] && !ioMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdHit) rdData <= {{PAD_W{1'b0}}, visible};
  end

  assign mgmtIrq = |visible;
endmodule

// File: rtl/sock_chg_latch.sv
module sock_chg_latch
  import sock_chg_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] REG_INDEX = 8'h04,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ioMode,
  input  logic [NUM_BITS-1:0] enMask,
  input  logic                cardDet1N,
  input  logic                cardDet2N,
  input  logic                rdyIreq,
  input  logic                bvd1,
  input  logic                bvd2,
  input  logic                rdStrobe,
  input  logic [IDX_W-1:0]    rdIndex,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic                mgmtIrq
);
  ctrlStrb_t           strb;
  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_BITS-1:0] statusQ, setVec;

  always_comb begin
    pinRaw           = '0;
    pinRaw[PIN_CD1]  = cardDet1N;
    pinRaw[PIN_CD2]  = cardDet2N;
    pinRaw[PIN_RDY]  = rdyIreq;
    pinRaw[PIN_BVD1] = bvd1;
    pinRaw[PIN_BVD2] = bvd2;
  end

  sock_chg_ctrl #(.IDX_W(IDX_W), .REG_INDEX(REG_INDEX)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdStrobe(rdStrobe),
    .rdIndex (rdIndex),
    .strb    (strb),
    .rdValid (rdValid)
  );

  sock_chg_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ioMode (ioMode),
    .enMask (enMask),
    .pinRaw (pinRaw),
    .strb   (strb),
    .rdData (rdData),
    .mgmtIrq(mgmtIrq),
    .statusQ(statusQ),
    .setVec (setVec)
  );
endmodule

// File: rtl/sock_chg_chk.sv
module sock_chg_chk
  import sock_chg_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] REG_INDEX = 8'h04,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                ioMode,
  input logic [NUM_BITS-1:0] enMask,
  input logic                rdStrobe,
  input logic [IDX_W-1:0]    rdIndex,
  input logic [DATA_W-1:0]   rdData,
  input logic                rdValid,
  input logic                mgmtIrq,
  input logic [NUM_BITS-1:0] statusQ,
  input logic [NUM_BITS-1:0] setVec
);
  logic hitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitQ <= 1'b0;
    else       hitQ <= rdStrobe && (rdIndex == REG_INDEX);
  end

  // R8: a valid pulse follows exactly the accepted strobes
  assert_valid_on_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == hitQ);

  // R8: padding bits stay zero
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData >> NUM_BITS) == '0);

  // R8/R9: the read returns only bits held before the clear
  assert_read_subset_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[NUM_BITS-1:0] & ~$past(statusQ)) == '0);

  // R6: ready flag hidden in I/O-card mode
  assert_io_ready_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(ioMode)) |-> !rdData[ST_READY]);

  // R9: flags are sticky between reads
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R7: a newly set flag had its enable on
  assert_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~$past(enMask)) == '0);

  // R10: a clean read drops the interrupt
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (hitQ && $past(setVec) == '0) |-> !mgmtIrq);
endmodule

bind sock_chg_latch sock_chg_chk #(
  .IDX_W(IDX_W), .REG_INDEX(REG_INDEX), .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ioMode  (ioMode),
  .enMask  (enMask),
  .rdStrobe(rdStrobe),
  .rdIndex (rdIndex),
  .rdData  (rdData),
  .rdValid (rdValid),
  .mgmtIrq (mgmtIrq),
  .statusQ (statusQ),
  .setVec  (setVec)
);

// File: tb/sock_chg_latch_tb.sv
`timescale 1ns/1ps
module sock_chg_latch_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ioMode = 1'b0;
  logic [3:0] enMask = 4'hF;
  logic       cardDet1N = 1'b0, cardDet2N = 1'b0, rdyIreq = 1'b1, bvd1 = 1'b1, bvd2 = 1'b1;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdIndex = 8'h00;
  logic [7:0] rdData;
  logic       rdValid, mgmtIrq;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sock_chg_latch u_dut (
    .clk(clk), .rstN(rstN), .ioMode(ioMode), .enMask(enMask),
    .cardDet1N(cardDet1N), .cardDet2N(cardDet2N), .rdyIreq(rdyIreq),
    .bvd1(bvd1), .bvd2(bvd2), .rdStrobe(rdStrobe), .rdIndex(rdIndex),
    .rdData(rdData), .rdValid(rdValid), .mgmtIrq(mgmtIrq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // three edges: two sync stages plus the edge/flag stage
  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic readReg(input logic [7:0] idx, output logic [7:0] d, output logic v);
    rdIndex = idx; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; rdIndex = 8'h00;
    d = rdData; v = rdValid;
  endtask

  task automatic readExpect(string tag, logic [7:0] exp);
    logic [7:0] d; logic v;
    readReg(8'h04, d, v);
    check({tag, " valid"}, {7'b0, v}, 8'h01);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    check("R1 rdData", rdData, 8'h00);
    check("R1 rdValid", {7'b0, rdValid}, 8'h00);
    check("R1 irq", {7'b0, mgmtIrq}, 8'h00);
  endtask

  task automatic t_cardDetect();
    cardDet1N = 1'b1; settle();
    check("R10 irq after cd", {7'b0, mgmtIrq}, 8'h01);
    readExpect("R2 cd1 rise", 8'h08);
    check("R10 irq after clean read", {7'b0, mgmtIrq}, 8'h00);
    readExpect("R9 cleared", 8'h00);
    cardDet2N = 1'b1; settle();
    readExpect("R2 cd2 rise", 8'h08);
    cardDet1N = 1'b0; settle();
    readExpect("R2 cd1 fall", 8'h08);
  endtask

  task automatic t_bvd1Mem();
    bvd1 = 1'b0; settle();
    readExpect("R3 bvd1 fall mem", 8'h01);
    bvd1 = 1'b1; settle();
    check("R3 irq on rise", {7'b0, mgmtIrq}, 8'h00);
    readExpect("R3 bvd1 rise mem", 8'h00);
  endtask

  task automatic t_bvd1Io();
    ioMode = 1'b1; @(negedge clk);
    bvd1 = 1'b0; settle();
    readExpect("R4 bvd1 fall io", 8'h01);
    bvd1 = 1'b1; settle();
    readExpect("R4 bvd1 rise io", 8'h01);
    ioMode = 1'b0; @(negedge clk);
  endtask

  task automatic t_bvd2();
    bvd2 = 1'b0; settle();
    readExpect("R5 bvd2 fall mem", 8'h02);
    bvd2 = 1'b1; settle();
    readExpect("R5 bvd2 rise mem", 8'h00);
    ioMode = 1'b1; @(negedge clk);
    bvd2 = 1'b0; settle();
    readExpect("R5 bvd2 fall io", 8'h00);
    bvd2 = 1'b1; settle();
    ioMode = 1'b0; @(negedge clk);
  endtask

  task automatic t_ready();
    rdyIreq = 1'b0; settle();
    readExpect("R6 rdy fall mem", 8'h04);
    rdyIreq = 1'b1; settle();
    readExpect("R6 rdy rise mem", 8'h04);
    ioMode = 1'b1; @(negedge clk);
    rdyIreq = 1'b0; settle();
    check("R6 irq io", {7'b0, mgmtIrq}, 8'h00);
    readExpect("R6 rdy io", 8'h00);
    rdyIreq = 1'b1; settle();
    ioMode = 1'b0; @(negedge clk);
  endtask

  task automatic t_enable();
    enMask = 4'h0;
    cardDet1N = 1'b1; settle();
    check("R7 irq masked", {7'b0, mgmtIrq}, 8'h00);
    readExpect("R7 all masked", 8'h00);
    enMask = 4'b1000;
    bvd1 = 1'b0; settle();
    readExpect("R7 bvd1 masked", 8'h00);
    cardDet1N = 1'b0; settle();
    readExpect("R7 cd enabled", 8'h08);
    bvd1 = 1'b1; enMask = 4'hF; settle();
    readExpect("R7 restore", 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] d; logic v;
    cardDet2N = 1'b0; settle();
    readReg(8'h05, d, v);
    check("R8 wrong index valid", {7'b0, v}, 8'h00);
    check("R8 wrong index irq", {7'b0, mgmtIrq}, 8'h01);
    readExpect("R8 right index", 8'h08);
    check("R8 valid one cycle", {7'b0, rdValid}, 8'h01);
    @(negedge clk);
    check("R8 valid drops", {7'b0, rdValid}, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] d; logic v;
    cardDet1N = 1'b1;
    repeat (2) @(negedge clk);
    readReg(8'h04, d, v);
    check("R9 collide read value", d, 8'h00);
    check("R9 collide irq", {7'b0, mgmtIrq}, 8'h01);
    readExpect("R9 event kept", 8'h08);
  endtask

  task automatic t_latency();
    rdyIreq = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 not yet", {7'b0, mgmtIrq}, 8'h00);
    @(negedge clk);
    check("R11 at third edge", {7'b0, mgmtIrq}, 8'h01);
    readExpect("R11 flag", 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    readExpect("R1 no spurious flag", 8'h00);
    t_cardDetect();
    t_bvd1Mem();
    t_bvd1Io();
    t_bvd2();
    t_ready();
    t_enable();
    t_index();
    t_collide();
    t_latency();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule